// File: doc/BRIEF.md
# Codec Power-Down Controller

This block owns the power-down request field of an audio codec's control register space and turns the requests into the enable lines that actually drive seven subsections: the ADC, the DAC, the analog mixer, the voltage reference, the serial link, the internal clock and the headphone driver. Software writes a 16-bit word. The request field lands in seven bits, and the word read back carries those bits together with four read-only ready flags.

The requests are not applied one by one. Ordering rules decide which enable really follows its request. Every analog subsection waits for the reference before it powers up. The reference and the mixer go down together only when both converters are also requested down. The link waits until every power-up already in progress has settled. The internal clock stops only after the converters and the link are off. Each ready flag follows a "settled" indication from the analog model of its subsection, and only while that subsection is enabled.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset the request field is all zero and every ready flag is 0. The reference, link and clock enables are 1, and the ADC, DAC, mixer and headphone enables are 0 until the reference is ready.
- R2: A write with `wr_en` high stores `wr_data[14:8]` into the request field on that clock edge. Bit 8 is ADC, 9 DAC, 10 mixer, 11 reference, 12 link, 13 clock and 14 headphone. `rd_data[14:8]` returns the field, `rd_data[3:0]` returns the ready flags (bit 0 ADC, 1 DAC, 2 mixer, 3 reference), and `rd_data[15]` and `rd_data[7:4]` read 0. Written bits 15 and 7:0 have no effect.
- R3: A ready flag sets one cycle after its `settled` bit is high while the subsection is enabled. Once set, it stays set for as long as the subsection stays enabled, whatever `settled` does.
- R4: A ready flag reads 0 in the same cycle that its subsection's enable is 0.
- R5: The ADC, DAC, mixer and headphone enables are 1 only when their own request bit is 0 and the reference ready flag is 1.
- R6: The reference enable is 0 only when the reference, ADC and DAC request bits are all 1. In that case the mixer enable is 0 as well.
- R7: The link enable is 0 only when its request bit is 1 and no enabled ADC, DAC, mixer or reference is still waiting for its ready flag.
- R8: The clock enable is 0 only when the clock, ADC and DAC request bits are 1 and the link enable is 0.
- R9: Writing all seven request bits as 1 (full standby) drives every enable and every ready flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write word |
| settled | input | 4 | Settled indication per flagged subsection (ADC, DAC, mixer, reference) |
| rd_data | output | 16 | Register read word |
| sub_en | output | 7 | Enables: 0 ADC, 1 DAC, 2 mixer, 3 reference, 4 link, 5 clock, 6 headphone |
| ready | output | 4 | Ready flags: 0 ADC, 1 DAC, 2 mixer, 3 reference |

## Verification
A write is visible on `rd_data` and on every enable in the cycle after the edge that takes it, because the enables are combinational from the request and ready registers. A ready flag rises one edge after `settled` is seen with its enable high, and it falls without delay when its enable falls. The bench drives inputs just after a falling edge. It advances its reference model on the rising edge and compares every output at the next falling edge, so each result is sampled in the cycle it is due.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  localparam int SUB_N   = 7;
  localparam int RDY_N   = 4;
  localparam int REG_W   = 16;
  localparam int REQ_LSB = 8;

  localparam int IDX_ADC  = 0;
  localparam int IDX_DAC  = 1;
  localparam int IDX_MIX  = 2;
  localparam int IDX_REF  = 3;
  localparam int IDX_LINK = 4;
  localparam int IDX_CLK  = 5;
  localparam int IDX_HP   = 6;

  typedef logic [SUB_N-1:0] sub_vec_t;
  typedef logic [RDY_N-1:0] rdy_vec_t;
endpackage

// File: rtl/pwrdn_rst_sync.sv
module pwrdn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/pwrdn_req_reg.sv
module pwrdn_req_reg
  import pwrdn_pkg::*;
#(
  parameter int W   = REG_W,
  parameter int LSB = REQ_LSB,
  parameter int N   = SUB_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] req_q;
  logic [N-1:0] req_d;

  always_comb begin
    req_d = req_q;
    if (wr_en_i) req_d = wr_data_i[LSB +: N];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end

  assign req_o = req_q;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en_i) |-> req_o == $past(wr_data_i[LSB +: N]));
  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en_i) |-> $stable(req_o));
endmodule

// File: rtl/pwrdn_gate.sv
module pwrdn_gate
  import pwrdn_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sub_vec_t req_i,
  input  rdy_vec_t rdy_q_i,
  output sub_vec_t en_o
);
  logic ref_on, ref_ok, link_hold, clk_off;
  rdy_vec_t flagged_en;

  always_comb begin
    ref_on = !(req_i[IDX_REF] && req_i[IDX_ADC] && req_i[IDX_DAC]);
    ref_ok = rdy_q_i[IDX_REF] && ref_on;

    flagged_en[IDX_REF] = ref_on;
    flagged_en[IDX_ADC] = !req_i[IDX_ADC] && ref_ok;
    flagged_en[IDX_DAC] = !req_i[IDX_DAC] && ref_ok;
    flagged_en[IDX_MIX] = !req_i[IDX_MIX] && ref_ok;

    link_hold = |(flagged_en & ~rdy_q_i);

    en_o = '0;
    en_o[RDY_N-1:0] = flagged_en;
    en_o[IDX_HP]    = !req_i[IDX_HP] && ref_ok;
    en_o[IDX_LINK]  = !(req_i[IDX_LINK] && !link_hold);
    clk_off         = req_i[IDX_CLK] && req_i[IDX_ADC] && req_i[IDX_DAC] && !en_o[IDX_LINK];
    en_o[IDX_CLK]   = !clk_off;
  end

  assert_ref_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o[IDX_ADC] || en_o[IDX_DAC] || en_o[IDX_MIX] || en_o[IDX_HP]) |-> rdy_q_i[IDX_REF]);
  assert_ref_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o[IDX_REF] |-> (req_i[IDX_ADC] && req_i[IDX_DAC] && !en_o[IDX_MIX]));
  assert_clk_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o[IDX_CLK] |-> (!en_o[IDX_LINK] && !en_o[IDX_ADC] && !en_o[IDX_DAC]));
endmodule

// File: rtl/pwrdn_ready_trk.sv
module pwrdn_ready_trk
  import pwrdn_pkg::*;
#(
  parameter int N = RDY_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] settled_i,
  output logic [N-1:0] rdy_q_o,
  output logic [N-1:0] ready_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic flag_q, flag_d;

    always_comb begin
      flag_d = en_i[k] && (flag_q || settled_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
    end

    assign rdy_q_o[k] = flag_q;
    assign ready_o[k] = flag_q && en_i[k];

    assert_rise_after_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o[k]) |-> ($past(settled_i[k]) && $past(en_i[k])));
    assert_drop_with_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i[k] |-> !ready_o[k]);
  end
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [RDY_N-1:0] settled,
  output logic [REG_W-1:0] rd_data,
  output logic [SUB_N-1:0] sub_en,
  output logic [RDY_N-1:0] ready
);
  logic     srst_n;
  sub_vec_t req;
  rdy_vec_t rdy_q;
  logic     unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:REQ_LSB+SUB_N], wr_data[REQ_LSB-1:0]};

  pwrdn_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(srst_n));

  pwrdn_req_reg #(.W(REG_W), .LSB(REQ_LSB), .N(SUB_N)) u_req (
    .clk(clk), .rst_n(srst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .req_o(req));

  pwrdn_gate u_gate (
    .clk(clk), .rst_n(srst_n), .req_i(req), .rdy_q_i(rdy_q), .en_o(sub_en));

  pwrdn_ready_trk #(.N(RDY_N)) u_rdy (
    .clk(clk), .rst_n(srst_n), .en_i(sub_en[RDY_N-1:0]), .settled_i(settled),
    .rdy_q_o(rdy_q), .ready_o(ready));

  always_comb begin
    rd_data = '0;
    rd_data[REQ_LSB +: SUB_N] = req;
    rd_data[RDY_N-1:0]        = ready;
  end

  assert_link_waits_R7: assert property (@(posedge clk) disable iff (!srst_n)
    !sub_en[IDX_LINK] |-> ((sub_en[RDY_N-1:0] & ~ready) == '0));
  assert_standby_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (&rd_data[REQ_LSB +: SUB_N]) |-> (sub_en == '0 && ready == '0));
endmodule

// File: tb/tb_pwrdn_ctrl.sv
module tb_pwrdn_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, wr_en;
  logic [15:0] wr_data, rd_data;
  logic [3:0]  settled, ready;
  logic [6:0]  sub_en;

  pwrdn_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .settled(settled), .rd_data(rd_data), .sub_en(sub_en), .ready(ready));

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [6:0] m_req;
  logic [3:0] m_rq;

  function automatic logic [6:0] f_en(logic [6:0] r, logic [3:0] q);
    logic [6:0] e;
    logic ref_on, ref_ok, pend;
    ref_on = !(r[3] && r[0] && r[1]);
    ref_ok = q[3] && ref_on;
    e[3] = ref_on;
    e[0] = !r[0] && ref_ok;
    e[1] = !r[1] && ref_ok;
    e[2] = !r[2] && ref_ok;
    e[6] = !r[6] && ref_ok;
    pend = |(e[3:0] & ~q);
    e[4] = !(r[4] && !pend);
    e[5] = !(r[5] && r[0] && r[1] && !e[4]);
    return e;
  endfunction

  function automatic string en_tag(int i);
    case (i)
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [6:0] e;
    e = f_en(m_req, m_rq);
    for (int i = 0; i < 7; i++) chk(en_tag(i), sub_en[i], e[i]);
    chk("R3", ready, m_rq & e[3:0]);
    chk("R4", ready & ~sub_en[3:0], 0);
    chk("R2", rd_data[14:8], m_req);
    chk("R2", {rd_data[15], rd_data[7:4]}, 0);
    chk("R2", rd_data[3:0], ready);
  endtask

  task automatic step(logic we, logic [15:0] wd, logic [3:0] st);
    logic [6:0] e;
    logic [3:0] nq;
    logic [6:0] nr;
    wr_en = we; wr_data = wd; settled = st;
    e  = f_en(m_req, m_rq);
    nq = e[3:0] & (m_rq | st);
    nr = we ? wd[14:8] : m_req;
    @(posedge clk);
    m_req = nr; m_rq = nq;
    @(negedge clk);
    wr_en = 1'b0;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1: watchdog act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; settled = '0;
    m_req = '0; m_rq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", rd_data, 16'h0000);
    chk("R1", sub_en, 7'b0111000);
    chk("R1", ready, 4'h0);
    check_all();

    // R3: reference settles, then the rest follow
    step(1'b0, 16'h0000, 4'b1000);
    chk("R3", ready, 4'b1000);
    chk("R5", sub_en, 7'b1111111);
    step(1'b0, 16'h0000, 4'b0111);
    step(1'b0, 16'h0000, 4'b0000);
    chk("R3", ready, 4'hF);

    // R2: bits outside the field are ignored
    step(1'b1, 16'h80FF, 4'b0000);
    chk("R2", rd_data, 16'h000F);

    // R4: ADC request drops its flag at once
    step(1'b1, 16'h0100, 4'b1111);
    chk("R4", ready[0], 1'b0);
    chk("R4", sub_en[0], 1'b0);

    // R8: clock request alone is not honoured
    step(1'b1, 16'h2100, 4'b0000);
    chk("R8", sub_en[5], 1'b1);
    step(1'b1, 16'h3300, 4'b0000);
    chk("R8", sub_en[5], 1'b0);
    chk("R7", sub_en[4], 1'b0);

    // R7: link held while converters are still coming up
    step(1'b1, 16'h0000, 4'b0000);
    step(1'b1, 16'h1000, 4'b0000);
    chk("R7", sub_en[4], 1'b1);
    step(1'b0, 16'h0000, 4'b0011);
    chk("R7", sub_en[4], 1'b0);

    // R6: reference request alone keeps reference up
    step(1'b1, 16'h0800, 4'b0000);
    chk("R6", sub_en[3], 1'b1);
    step(1'b1, 16'h0B00, 4'b0000);
    chk("R6", sub_en[3], 1'b0);
    chk("R6", sub_en[2], 1'b0);

    // R9 full standby
    step(1'b1, 16'h7F00, 4'b1111);
    chk("R9", sub_en, 7'h00);
    chk("R9", ready, 4'h0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] wd;
      wd = 16'($urandom);
      if ($urandom % 3 == 0) wd[14:8] = wd[14:8] | 7'($urandom);
      step(($urandom % 4) == 0, wd, 4'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule